// File: doc/BRIEF.md
# Time-Multiplexed Fault Injection Register Array

This block replaces every state flip-flop of a circuit under test with a cell that holds two copies of the state: one for the fault-free (golden) machine and one for the faulty machine. A single copy of the combinational logic serves both machines. It does this on alternating clock phases. In phase 0 the cells drive golden bits into the logic and capture the golden next state. In phase 1 they drive faulty bits and capture the faulty next state. One stimulus vector therefore occupies two clocks.

Each cell also keeps a fault-mask bit and a checkpoint bit. An inject command makes the faulty copy equal to the golden copy with the masked bits inverted. This gives a bit-flip fault on the chosen memory elements. A save command stores the golden state as a checkpoint. A restore command reloads both copies from the checkpoint, so the next experiment does not have to replay the stimulus from the beginning.

A phase controller latches the golden outputs in phase 0. It compares them with the faulty outputs in phase 1 and keeps a sticky output-mismatch flag. The controller ORs together the per-cell difference flags. When the fault has left the state without ever reaching the outputs, the controller declares the fault silent and freezes the array, which ends the experiment at once. The array wraps a small parameterised test circuit of N state bits and OUT_W outputs.

Top module: `tmfi_array`

## Requirements
- R1: After reset the phase is 0, and all golden, faulty, mask and checkpoint bits are 0. state_o, diff_o and out_o are 0, and out_mismatch_o and fault_silent_o are 0.
- R2: A step happens on a clock where run is 1, fault_silent_o is 0, and neither inject nor restore is 1. Each step toggles the phase. Inject or restore forces the phase to 0. In every other case the phase holds.
- R3: state_o shows the golden bits when the phase is 0 and the faulty bits when the phase is 1. A step in phase 0 loads the next state into the golden bits only. A step in phase 1 loads it into the faulty bits only.
- R4: The test circuit computes next[i] = stim[i] ? s[(i-1) mod N] : stim[(i+1) mod N], where s is state_o. Output bit j is the XOR of s[k] over k in N/2..N-1 with k mod OUT_W = j.
- R5: mask_wr loads mask_in into the mask bits. Inject sets the faulty bits to the golden bits XOR the mask held before that clock, and leaves the golden bits unchanged.
- R6: Save copies the golden bits, as they were before the clock, into the checkpoint. Restore loads the checkpoint into both the golden and the faulty bits. Priority is restore, then inject, then step.
- R7: diff_o[i] is 1 exactly when golden bit i differs from faulty bit i.
- R8: A phase-0 step latches out_o. A phase-1 step sets out_mismatch_o if out_o differs from the latched value. The flag stays set until inject or restore clears it.
- R9: Inject arms the experiment and restore disarms it. fault_silent_o is 1 when the experiment is armed, diff_o is all zero and out_mismatch_o is 0. While fault_silent_o is 1, run has no effect and the state is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Advance one phase per clock |
| stim | input | N | Stimulus vector for the test circuit |
| mask_wr | input | 1 | Load the fault mask |
| mask_in | input | N | New fault-mask value |
| inject | input | 1 | Start an experiment: faulty = golden XOR mask |
| save | input | 1 | Checkpoint the golden state |
| restore | input | 1 | Reload both copies from the checkpoint |
| phase_o | output | 1 | Current phase (0 golden, 1 faulty) |
| state_o | output | N | State bits driven into the logic |
| diff_o | output | N | Per-cell golden/faulty difference |
| out_o | output | OUT_W | Test-circuit outputs for the driven state |
| out_mismatch_o | output | 1 | Sticky faulty-output mismatch |
| fault_silent_o | output | 1 | Fault vanished without an output error |

## Verification
A wrong golden bit shows on state_o in the next phase-0 clock. A wrong faulty bit shows in the next phase-1 clock, and in both cases diff_o shows it on the clock after the faulty write. A wrong output latch or compare shows as a wrong out_mismatch_o flag on the clock after the phase-1 step. A wrong armed flag or a wrong difference OR shows on fault_silent_o immediately, and it then shows as a frozen or still-running phase on the following clock. The bench compares every port with a behavioural model on every clock, so a divergence is reported within one to two clocks of its cause.

// File: rtl/tmfi_pkg.sv
package tmfi_pkg;
    typedef enum logic {
        PH_GOLD  = 1'b0,
        PH_FAULT = 1'b1
    } phase_e;

    typedef struct packed {
        logic golden;
        logic faulty;
        logic mask;
        logic saved;
    } cell_s;
endpackage

// File: rtl/tmfi_cell.sv
module tmfi_cell
    import tmfi_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_i,
    input  logic   step_i,
    input  logic   next_i,
    input  logic   mask_wr_i,
    input  logic   mask_i,
    input  logic   inject_i,
    input  logic   save_i,
    input  logic   restore_i,
    output logic   q_o,
    output logic   diff_o,
    output logic   mask_o
);
    cell_s cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (mask_wr_i) cell_d.mask = mask_i;
        if (save_i)    cell_d.saved = cell_q.golden;
        if (restore_i) begin
            cell_d.golden = cell_q.saved;
            cell_d.faulty = cell_q.saved;
        end else if (inject_i) begin
            cell_d.faulty = cell_q.golden ^ cell_q.mask;
        end else if (step_i) begin
            if (phase_i == PH_GOLD) cell_d.golden = next_i;
            else                    cell_d.faulty = next_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign q_o    = (phase_i == PH_GOLD) ? cell_q.golden : cell_q.faulty;
    assign diff_o = cell_q.golden ^ cell_q.faulty;
    assign mask_o = cell_q.mask;
endmodule

// File: rtl/tmfi_test_logic.sv
module tmfi_test_logic #(
    parameter int N     = 8,
    parameter int OUT_W = 2
) (
    input  logic [N-1:0]     st_i,
    input  logic [N-1:0]     stim_i,
    output logic [N-1:0]     next_o,
    output logic [OUT_W-1:0] out_o
);
    localparam int OBS_LO = N / 2;

    for (genvar i = 0; i < N; i++) begin : g_next
        localparam int PREV = (i + N - 1) % N;
        localparam int SUCC = (i + 1) % N;
        assign next_o[i] = stim_i[i] ? st_i[PREV] : stim_i[SUCC];
    end

    always_comb begin
        out_o = '0;
        for (int k = OBS_LO; k < N; k++) begin
            out_o[k % OUT_W] = out_o[k % OUT_W] ^ st_i[k];
        end
    end
endmodule

// File: rtl/tmfi_phase_ctrl.sv
module tmfi_phase_ctrl
    import tmfi_pkg::*;
#(
    parameter int OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             inject_i,
    input  logic             restore_i,
    input  logic             any_diff_i,
    input  logic [OUT_W-1:0] out_i,
    output phase_e           phase_o,
    output logic             step_o,
    output logic             mismatch_o,
    output logic             silent_o
);
    typedef struct packed {
        phase_e           phase;
        logic [OUT_W-1:0] gout;
        logic             mis;
        logic             armed;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;
    logic  silent, step;

    always_comb begin
        silent = ctl_q.armed & ~any_diff_i & ~ctl_q.mis;
        step   = run_i & ~silent & ~inject_i & ~restore_i;
        ctl_d  = ctl_q;
        if (restore_i) begin
            ctl_d.phase = PH_GOLD;
            ctl_d.mis   = 1'b0;
            ctl_d.armed = 1'b0;
        end else if (inject_i) begin
            ctl_d.phase = PH_GOLD;
            ctl_d.mis   = 1'b0;
            ctl_d.armed = 1'b1;
        end else if (step) begin
            if (ctl_q.phase == PH_GOLD) begin
                ctl_d.gout  = out_i;
                ctl_d.phase = PH_FAULT;
            end else begin
                if (out_i != ctl_q.gout) ctl_d.mis = 1'b1;
                ctl_d.phase = PH_GOLD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign phase_o    = ctl_q.phase;
    assign step_o     = step;
    assign mismatch_o = ctl_q.mis;
    assign silent_o   = silent;
endmodule

// File: rtl/tmfi_array.sv
module tmfi_array
    import tmfi_pkg::*;
#(
    parameter int N     = 8,
    parameter int OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [N-1:0]     stim,
    input  logic             mask_wr,
    input  logic [N-1:0]     mask_in,
    input  logic             inject,
    input  logic             save,
    input  logic             restore,
    output logic             phase_o,
    output logic [N-1:0]     state_o,
    output logic [N-1:0]     diff_o,
    output logic [OUT_W-1:0] out_o,
    output logic             out_mismatch_o,
    output logic             fault_silent_o
);
    phase_e       phase;
    logic         step;
    logic [N-1:0] next_st;
    logic [N-1:0] mask_vec;

    tmfi_phase_ctrl #(.OUT_W(OUT_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .inject_i   (inject),
        .restore_i  (restore),
        .any_diff_i (|diff_o),
        .out_i      (out_o),
        .phase_o    (phase),
        .step_o     (step),
        .mismatch_o (out_mismatch_o),
        .silent_o   (fault_silent_o)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        tmfi_cell cell_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .phase_i   (phase),
            .step_i    (step),
            .next_i    (next_st[i]),
            .mask_wr_i (mask_wr),
            .mask_i    (mask_in[i]),
            .inject_i  (inject),
            .save_i    (save),
            .restore_i (restore),
            .q_o       (state_o[i]),
            .diff_o    (diff_o[i]),
            .mask_o    (mask_vec[i])
        );
    end

    tmfi_test_logic #(.N(N), .OUT_W(OUT_W)) logic_i (
        .st_i   (state_o),
        .stim_i (stim),
        .next_o (next_st),
        .out_o  (out_o)
    );

    assign phase_o = phase;
endmodule

// File: rtl/tmfi_array_chk.sv
module tmfi_array_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         inject,
    input logic         restore,
    input logic         phase_o,
    input logic [N-1:0] state_o,
    input logic [N-1:0] diff_o,
    input logic [N-1:0] mask_vec,
    input logic         out_mismatch_o,
    input logic         fault_silent_o
);
    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        run && !fault_silent_o && !inject && !restore |=> phase_o != $past(phase_o)); // R2
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !inject && !restore |=> $stable(phase_o)); // R2
    AST_INJECT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        inject && !restore |=> diff_o == $past(mask_vec)); // R5
    AST_RESTORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> diff_o == '0 && !phase_o); // R6
    AST_MISMATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        inject || restore |=> !out_mismatch_o); // R8
    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        out_mismatch_o && !inject && !restore |=> out_mismatch_o); // R8
    AST_SILENT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_silent_o && !inject && !restore |=> $stable(state_o) && $stable(phase_o)); // R9
endmodule

bind tmfi_array tmfi_array_chk #(.N(N)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .run            (run),
    .inject         (inject),
    .restore        (restore),
    .phase_o        (phase_o),
    .state_o        (state_o),
    .diff_o         (diff_o),
    .mask_vec       (mask_vec),
    .out_mismatch_o (out_mismatch_o),
    .fault_silent_o (fault_silent_o)
);

// File: tb/tmfi_array_tb_top.sv
module tmfi_array_tb_top;
    localparam int N = 8;
    localparam int OW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0, mask_wr = 1'b0, inject = 1'b0, save = 1'b0, restore = 1'b0;
    logic [N-1:0]  stim = '0, mask_in = '0;
    logic          phase_o, out_mismatch_o, fault_silent_o;
    logic [N-1:0]  state_o, diff_o;
    logic [OW-1:0] out_o;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    logic [N-1:0]  mg = '0, mf = '0, mm = '0, ms = '0;
    logic          mph = 1'b0, mmis = 1'b0, marm = 1'b0;
    logic [OW-1:0] mgout = '0;

    always #2 clk = ~clk;

    tmfi_array #(.N(N), .OUT_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .stim(stim), .mask_wr(mask_wr),
        .mask_in(mask_in), .inject(inject), .save(save), .restore(restore),
        .phase_o(phase_o), .state_o(state_o), .diff_o(diff_o), .out_o(out_o),
        .out_mismatch_o(out_mismatch_o), .fault_silent_o(fault_silent_o)
    );

    function automatic logic [N-1:0] f_next(input logic [N-1:0] st, input logic [N-1:0] sb);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = sb[i] ? st[(i + N - 1) % N] : sb[(i + 1) % N];
        return r;
    endfunction

    function automatic logic [OW-1:0] f_out(input logic [N-1:0] st);
        logic [OW-1:0] r = '0;
        for (int k = N / 2; k < N; k++) r[k % OW] = r[k % OW] ^ st[k];
        return r;
    endfunction

    function automatic logic m_silent();
        return marm && ((mg ^ mf) == '0) && !mmis;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [N-1:0] drv;
        drv = mph ? mf : mg;
        chk("R2", "phase", 32'(phase_o), 32'(mph));
        chk("R3", "state", 32'(state_o), 32'(drv));
        chk("R4", "out", 32'(out_o), 32'(f_out(drv)));
        chk("R7", "diff", 32'(diff_o), 32'(mg ^ mf));
        chk("R8", "mismatch", 32'(out_mismatch_o), 32'(mmis));
        chk("R9", "silent", 32'(fault_silent_o), 32'(m_silent()));
    endtask

    task automatic model_clock();
        logic [N-1:0] g0, f0, m0, s0, drv;
        logic stp;
        g0 = mg; f0 = mf; m0 = mm; s0 = ms;
        drv = mph ? f0 : g0;
        stp = run && !m_silent() && !inject && !restore;
        if (mask_wr) mm = mask_in;
        if (save) ms = g0;
        if (restore) begin
            mg = s0; mf = s0; mph = 1'b0; mmis = 1'b0; marm = 1'b0;
        end else if (inject) begin
            mf = g0 ^ m0; mph = 1'b0; mmis = 1'b0; marm = 1'b1;
        end else if (stp) begin
            if (!mph) begin
                mg = f_next(drv, stim); mgout = f_out(drv); mph = 1'b1;
            end else begin
                mf = f_next(drv, stim);
                if (f_out(drv) != mgout) mmis = 1'b1;
                mph = 1'b0;
            end
        end
    endtask

    task automatic cyc(input logic r, input logic [N-1:0] s, input logic mw, input logic [N-1:0] mi,
                       input logic inj, input logic sv, input logic rs);
        run = r; stim = s; mask_wr = mw; mask_in = mi; inject = inj; save = sv; restore = rs;
        @(posedge clk);
        model_clock();
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "reset state", {state_o, diff_o, 6'(out_o), 2'(phase_o), 1'(out_mismatch_o), 1'(fault_silent_o)}, '0);
        compare_all();

        // warm up golden/faulty together
        for (int i = 0; i < 10; i++) cyc(1, 8'(i * 37 + 5), 0, '0, 0, 0, 0);
        // R6: checkpoint at phase 0
        cyc(0, '0, 1, 8'h04, 0, 1, 0);
        // R5: inject a flip on bit 2
        cyc(0, '0, 0, '0, 1, 0, 0);
        chk("R5", "inject diff", 32'(diff_o), 32'h04);
        // persistent fault: rotate until visible at outputs
        for (int i = 0; i < 8; i++) cyc(1, 8'hFF, 0, '0, 0, 0, 0);
        chk("R8", "mismatch after rotation", 32'(out_mismatch_o), 32'h1);
        // R2: run low holds
        cyc(0, 8'hFF, 0, '0, 0, 0, 0);
        cyc(0, 8'hFF, 0, '0, 0, 0, 0);
        // R6: restore
        cyc(0, '0, 0, '0, 0, 0, 1);
        chk("R6", "restore diff", 32'(diff_o), 32'h0);
        chk("R6", "restore state", 32'(state_o), 32'(ms));
        // vanishing fault: zero stim clears bit 2 before outputs see it
        cyc(0, '0, 0, '0, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 8'h00, 0, '0, 0, 0, 0);
        chk("R9", "silent after vanish", 32'(fault_silent_o), 32'h1);
        // frozen while silent
        for (int i = 0; i < 3; i++) cyc(1, 8'hFF, 0, '0, 0, 0, 0);
        chk("R9", "frozen phase", 32'(phase_o), 32'h0);
        // empty mask: silent at once
        cyc(0, '0, 1, 8'h00, 0, 0, 1);
        cyc(0, '0, 0, '0, 1, 0, 0);
        chk("R9", "empty mask silent", 32'(fault_silent_o), 32'h1);
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            cyc(rv[0] | rv[1], 8'(rv[15:8]), rv[20:18] == 3'd0, 8'(rv[31:24]),
                rv[25:21] == 5'd0, rv[30:27] == 4'd0, rv[17:13] == 5'd1);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule